// File: doc/BRIEF.md
# Wait-State Memory Strobe Sequencer

This block runs the external memory port of a processor whose instruction cycle is split into four quarter phases. It is clocked at four times the cycle rate and keeps its own quarter-phase count, which it shows as a cycle clock output: high in the first two quarters, low in the last two. A core request gives a 14-bit address, a memory space, a direction, write data and a wait count. Requests are taken only in the last quarter of a cycle, so that each access starts on a cycle boundary.

An access lasts one cycle plus its wait states. The address and the active-low space select are driven in the first quarter. The read or write strobe falls one quarter after the cycle boundary and stays low for half a cycle plus four quarters per wait state. The address and select are then held for one more quarter. Write data is driven from the falling edge of the write strobe until one quarter after its rising edge. Read data is captured on the edge at which the read strobe rises and handed back to the core with a one-quarter valid pulse. A new request can be taken in the hold quarter of the previous access. The strobes are then separated by exactly half a cycle, and the data bus is already released one quarter before the next strobe falls.

Top module: `mem_strobe_seq`

## Requirements
- R1: While reset is asserted and after it is released with no request, rd_n and wr_n are high, space_sel_n is 3'b111, dq_oe is low, busy is low and rd_valid is low.
- R2: req_taken is high only when req_valid is high, req_space is 0, 1 or 2, the cycle clock is low in its last quarter, and the sequencer is idle or in its hold quarter. A request with req_space = 3 is never taken and starts no access.
- R3: In the quarter after a request is taken, mem_addr equals the request address and exactly one select is low. Space code 0 maps to bit 0 (program), code 1 to bit 1 (data) and code 2 to bit 2 (boot). This setup quarter comes directly before the strobe falls.
- R4: The strobe (rd_n for req_write = 0, wr_n for req_write = 1) falls in the second quarter of a cycle. It stays low for 2 + 4*W quarters, where W is the req_waits value sampled when the request was taken.
- R5: mem_addr and the select stay unchanged while the strobe is low and during the one quarter after it rises.
- R6: After a strobe rises, both strobes stay high for at least two quarters before any strobe falls again.
- R7: For a write, dq_oe rises on the same edge as wr_n falls, dq_out carries the write data, and dq_oe stays high for one quarter after wr_n rises and then drops. dq_oe is never high during a read strobe, and it is low in the quarter before any strobe falls.
- R8: For a read, rd_data equals the dq_in value present at the edge where rd_n rises, and rd_valid is high for exactly the following quarter. rd_valid stays low for writes.
- R9: busy is high from the quarter after a request is taken through the hold quarter, and low when no access is in progress.
- R10: rd_n and wr_n are never low together, and at most one select is low at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Quarter-phase clock, four times the cycle rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core asks for an access; held until req_taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 2 | 0 program, 1 data, 2 boot, 3 invalid |
| req_addr | input | 14 | Access address |
| req_wdata | input | 16 | Write data |
| req_waits | input | 3 | Whole-cycle wait states for this access |
| req_taken | output | 1 | Request accepted at this clock edge |
| busy | output | 1 | Access in progress |
| cyc_clk | output | 1 | Cycle clock, high in quarters 0 and 1 |
| mem_addr | output | 14 | External address |
| space_sel_n | output | 3 | Active-low space selects (bit 0 program, 1 data, 2 boot) |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| dq_out | output | 16 | Data driven to memory |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | 16 | Data returned by memory |
| rd_data | output | 16 | Captured read data to the core |
| rd_valid | output | 1 | rd_data updated, one-quarter pulse |

## Verification
The bench builds the block with its defaults: a 14-bit address, 16-bit data and a 3-bit wait count. This puts every wait count from zero to seven in reach, so strobe widths from 2 to 30 quarters are measured, including the longest. The default address width lets the accesses use the lowest and highest addresses. The same build lets the bench chain requests through the hold quarter, which tests the minimum half-cycle gap and the bus release before the next strobe. It also lets the bench present the unused space code.

// File: rtl/mss_pkg.sv
package mss_pkg;
  // Quarter-phase scheme: one cycle = four clocks
  localparam int unsigned QTR_PER_CYCLE = 4;
  // Strobe base width in quarters (half a cycle)
  localparam int unsigned STROBE_BASE_Q = QTR_PER_CYCLE / 2;

  typedef enum logic [1:0] {
    MS_IDLE   = 2'd0,
    MS_SETUP  = 2'd1,
    MS_STROBE = 2'd2,
    MS_HOLD   = 2'd3
  } mss_state_e;
endpackage

// File: rtl/mss_rst_sync.sv
module mss_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/mss_phase_ctr.sv
module mss_phase_ctr #(
  parameter int unsigned PHASES = 4,
  localparam int unsigned PW = $clog2(PHASES)
) (
  input  logic clk,
  input  logic rst_n,
  output logic last_q,
  output logic cyc_clk
);
  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_d;

  always_comb begin
    if (last_q) phase_d = '0;
    else        phase_d = phase_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign last_q  = (phase_q == PW'(PHASES - 1));
  assign cyc_clk = (phase_q <  PW'(PHASES / 2));
endmodule

// File: rtl/mss_len_ctr.sv
module mss_len_ctr #(
  parameter int unsigned WAIT_W = 3,
  parameter int unsigned PHASES = 4,
  parameter int unsigned BASE   = 2,
  localparam int unsigned CNT_W = $clog2(BASE + PHASES * ((1 << WAIT_W) - 1))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [WAIT_W-1:0] waits,
  output logic              done
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] load_val;
  logic             cnt_en;

  // Remaining strobe quarters minus one: BASE-1 + PHASES*waits
  assign load_val = CNT_W'(BASE - 1) + CNT_W'(PHASES) * CNT_W'(waits);
  assign cnt_en   = load || (run && !done);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/mss_fsm.sv
module mss_fsm
  import mss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       last_q,
  input  logic       req_valid,
  input  logic       space_ok,
  input  logic       len_done,
  output mss_state_e state,
  output logic       take
);
  mss_state_e state_d;
  logic       can_take;

  assign can_take = (state == MS_IDLE) || (state == MS_HOLD);
  assign take     = req_valid && space_ok && last_q && can_take;

  always_comb begin
    state_d = state;
    unique case (state)
      MS_IDLE:   if (take) state_d = MS_SETUP;
      MS_SETUP:  state_d = MS_STROBE;
      MS_STROBE: if (len_done) state_d = MS_HOLD;
      MS_HOLD:   state_d = take ? MS_SETUP : MS_IDLE;
      default:   state_d = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= MS_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/mem_strobe_seq.sv
module mem_strobe_seq
  import mss_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WAIT_W = 3,
  parameter int unsigned SPACES = 3,
  localparam int unsigned SPACE_W = $clog2(SPACES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [SPACE_W-1:0] req_space,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [WAIT_W-1:0] req_waits,
  output logic              req_taken,
  output logic              busy,
  output logic              cyc_clk,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [SPACES-1:0] space_sel_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic              rst_n_s;
  logic              last_q;
  logic              space_ok;
  logic              len_done;
  logic              take;
  mss_state_e        state;
  logic              active;
  logic              in_strobe;
  logic              cap_en;

  logic              lat_write;
  logic [SPACE_W-1:0] lat_space;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic [WAIT_W-1:0] lat_waits;

  mss_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  mss_phase_ctr #(.PHASES(QTR_PER_CYCLE)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .last_q  (last_q),
    .cyc_clk (cyc_clk)
  );

  assign space_ok = ({1'b0, req_space} < (SPACE_W + 1)'(SPACES));

  mss_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .last_q    (last_q),
    .req_valid (req_valid),
    .space_ok  (space_ok),
    .len_done  (len_done),
    .state     (state),
    .take      (take)
  );

  mss_len_ctr #(
    .WAIT_W (WAIT_W),
    .PHASES (QTR_PER_CYCLE),
    .BASE   (STROBE_BASE_Q)
  ) u_len (
    .clk   (clk),
    .rst_n (rst_n_s),
    .load  (state == MS_SETUP),
    .run   (state == MS_STROBE),
    .waits (lat_waits),
    .done  (len_done)
  );

  // Request latch: wait count and address sampled when taken
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      lat_write <= 1'b0;
      lat_space <= '0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_waits <= '0;
    end else if (take) begin
      lat_write <= req_write;
      lat_space <= req_space;
      lat_addr  <= req_addr;
      lat_wdata <= req_wdata;
      lat_waits <= req_waits;
    end
  end

  assign active    = (state != MS_IDLE);
  assign in_strobe = (state == MS_STROBE);

  for (genvar i = 0; i < SPACES; i++) begin : g_sel
    assign space_sel_n[i] = !(active && (lat_space == SPACE_W'(i)));
  end

  assign req_taken = take;
  assign busy      = active;
  assign mem_addr  = lat_addr;
  assign rd_n      = !(in_strobe && !lat_write);
  assign wr_n      = !(in_strobe &&  lat_write);
  assign dq_oe     = lat_write && (in_strobe || (state == MS_HOLD));
  assign dq_out    = lat_wdata;

  // Read capture on the edge where the read strobe rises
  assign cap_en = in_strobe && len_done && !lat_write;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap_en;
      if (cap_en) rd_data <= dq_in;
    end
  end
endmodule

// File: rtl/mss_checker.sv
module mss_checker #(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned SPACES = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_clk,
  input logic              busy,
  input logic              rd_n,
  input logic              wr_n,
  input logic              dq_oe,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [SPACES-1:0] space_sel_n
);
  logic strb;
  assign strb = !rd_n || !wr_n;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R10
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~space_sel_n) <= 1); // R10
  AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    strb |-> (space_sel_n != '1)); // R5
  AST_FALL_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(wr_n)) |-> (cyc_clk && $past(cyc_clk))); // R4
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && $past(strb)) |-> $stable(mem_addr)); // R5
  AST_GAP_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_n) || $rose(wr_n)) |=> (rd_n && wr_n)); // R6
  AST_OE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> rd_n); // R7
  AST_OE_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $fell(wr_n)); // R7
  AST_RDV_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(!rd_n) && rd_n)); // R8
  AST_BUSY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    strb |-> busy); // R9
endmodule

bind mem_strobe_seq mss_checker #(.ADDR_W(ADDR_W), .SPACES(SPACES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cyc_clk     (cyc_clk),
  .busy        (busy),
  .rd_n        (rd_n),
  .wr_n        (wr_n),
  .dq_oe       (dq_oe),
  .rd_valid    (rd_valid),
  .mem_addr    (mem_addr),
  .space_sel_n (space_sel_n)
);

// File: tb/mem_strobe_seq_test.sv
module mem_strobe_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [1:0]  req_space;
  logic [13:0] req_addr;
  logic [15:0] req_wdata;
  logic [2:0]  req_waits;
  logic        req_taken;
  logic        busy;
  logic        cyc_clk;
  logic [13:0] mem_addr;
  logic [2:0]  space_sel_n;
  logic        rd_n;
  logic        wr_n;
  logic [15:0] dq_out;
  logic        dq_oe;
  logic [15:0] dq_in;
  logic [15:0] rd_data;
  logic        rd_valid;

  mem_strobe_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_waits(req_waits), .req_taken(req_taken), .busy(busy),
    .cyc_clk(cyc_clk), .mem_addr(mem_addr), .space_sel_n(space_sel_n),
    .rd_n(rd_n), .wr_n(wr_n), .dq_out(dq_out), .dq_oe(dq_oe),
    .dq_in(dq_in), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  typedef struct {
    bit          wr;
    logic [1:0]  sp;
    logic [13:0] a;
    logic [15:0] d;
    int          w;
  } exp_t;

  exp_t expq[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   mon_en   = 0;
  bit   done     = 0;

  function automatic logic [15:0] mem_model(input logic [13:0] a);
    return {2'b10, a} ^ 16'h1234;
  endfunction

  function automatic logic [2:0] sel_of(input logic [1:0] sp);
    return ~(3'b001 << sp);
  endfunction

  assign dq_in = rd_n ? 16'h0000 : mem_model(mem_addr);

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: presents a request, pushes the expected access once taken
  task automatic access(input bit wr, input logic [1:0] sp, input logic [13:0] a,
                        input logic [15:0] d, input int w);
    exp_t e;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_space = sp; req_addr = a;
    req_wdata = d; req_waits = 3'(w);
    forever begin
      #1;
      if (req_taken) break;
      @(negedge clk);
    end
    check(cyc_clk == 0, "R2 taken in low cycle-clock quarter", cyc_clk, 0);
    e.wr = wr; e.sp = sp; e.a = a; e.d = d; e.w = w;
    expq.push_back(e);
    @(negedge clk);
    req_valid = 0; req_waits = 3'(w) ^ 3'h7; req_addr = ~a; req_wdata = ~d;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    repeat (2) @(negedge clk);
  endtask

  // Monitor
  exp_t cur;
  bit   prev_low = 0, hold_prev = 0;
  logic cyc_h1 = 0, cyc_h2 = 0;
  logic [13:0] prev_addr = '0;
  logic [2:0]  prev_sel = 3'b111;
  int   width = 0, gap = 100;

  always @(negedge clk) begin
    bit low;
    if (mon_en) begin
      low = !rd_n || !wr_n;
      if (low && !prev_low) begin
        if (expq.size() == 0) begin
          check(0, "R2 unexpected strobe", 1, 0);
          cur = '{default: 0};
        end else cur = expq.pop_front();
        check(cyc_clk && cyc_h1 && !cyc_h2, "R4 fall in second quarter", {cyc_h2, cyc_h1, cyc_clk}, 3'b011);
        check(prev_addr == cur.a, "R3 setup address", prev_addr, cur.a);
        check(prev_sel == sel_of(cur.sp), "R3 setup select", prev_sel, sel_of(cur.sp));
        check(space_sel_n == sel_of(cur.sp), "R3 select at strobe", space_sel_n, sel_of(cur.sp));
        check(wr_n == !cur.wr && rd_n == cur.wr, "R4 strobe kind", {rd_n, wr_n}, {cur.wr, !cur.wr});
        check(gap >= 2, "R6 strobe gap", gap, 2);
        if (cur.wr) check(dq_oe && dq_out == cur.d, "R7 write data at fall", dq_out, cur.d);
        else        check(!dq_oe, "R7 bus off for read", dq_oe, 0);
        check(busy, "R9 busy during strobe", busy, 1);
        check(!(!rd_n && !wr_n) && $countones(~space_sel_n) == 1, "R10 exclusive", {rd_n, wr_n, space_sel_n}, 0);
        width = 1;
      end else if (low) begin
        width++;
        check(mem_addr == cur.a, "R5 address held in strobe", mem_addr, cur.a);
      end
      if (!low && prev_low) begin
        check(width == 2 + 4 * cur.w, "R4 strobe width", width, 2 + 4 * cur.w);
        check(mem_addr == cur.a && space_sel_n == sel_of(cur.sp), "R5 hold quarter", mem_addr, cur.a);
        check(dq_oe == cur.wr, "R7 data held after rise", dq_oe, cur.wr);
        check(busy, "R9 busy in hold", busy, 1);
        if (!cur.wr) check(rd_valid && rd_data == mem_model(cur.a), "R8 read data", rd_data, mem_model(cur.a));
        else         check(!rd_valid, "R8 no valid on write", rd_valid, 0);
        gap = 1;
        hold_prev = 1;
      end else if (!low) begin
        gap++;
        if (hold_prev) begin
          check(!dq_oe && !rd_valid, "R7 bus released", {dq_oe, rd_valid}, 0);
          hold_prev = 0;
        end
      end
      prev_low = low; cyc_h2 = cyc_h1; cyc_h1 = cyc_clk;
      prev_addr = mem_addr; prev_sel = space_sel_n;
    end
  end

  task automatic check_idle(input string tag);
    check(rd_n && wr_n && space_sel_n == 3'b111 && !dq_oe && !busy && !rd_valid,
          tag, {rd_n, wr_n, space_sel_n, dq_oe, busy, rd_valid}, 8'b11111000);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_space = 0;
    req_addr = 0; req_wdata = 0; req_waits = 0;
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1;
    repeat (6) @(negedge clk);
    check_idle("R1 after release");
    mon_en = 1;

    access(0, 2'd0, 14'h0001, 16'h0000, 0);
    access(1, 2'd1, 14'h3FFF, 16'hBEEF, 0);
    access(0, 2'd2, 14'h2AAA, 16'h0000, 3);
    access(1, 2'd0, 14'h1555, 16'h0F0F, 7);
    wait_idle();
    check_idle("R9 idle after accesses");

    // Back-to-back through the hold quarter
    access(0, 2'd1, 14'h0000, 16'h0000, 0);
    access(0, 2'd2, 14'h1234, 16'h0000, 0);
    access(0, 2'd0, 14'h3210, 16'h0000, 0);
    access(1, 2'd1, 14'h0ABC, 16'hA5A5, 1);
    access(0, 2'd1, 14'h0ABC, 16'h0000, 1);
    access(1, 2'd2, 14'h3001, 16'h5A5A, 2);
    access(0, 2'd0, 14'h0777, 16'h0000, 0);
    wait_idle();

    // Invalid space code 3 is never taken
    @(negedge clk);
    req_valid = 1; req_space = 2'd3; req_write = 0; req_addr = 14'h0042;
    for (int i = 0; i < 8; i++) begin
      #1;
      check(!req_taken, "R2 space 3 not taken", req_taken, 0);
      @(negedge clk);
    end
    req_valid = 0; req_space = 0;
    check_idle("R2 space 3 starts nothing");

    wait_idle();
    check(expq.size() == 0, "R4 all accesses seen", expq.size(), 0);
    check_idle("R9 final idle");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule